// File: doc/BRIEF.md
# Byte-lane static RAM sequencer

This block sits between a synchronous request port and an external asynchronous static RAM of 64K words of 16 bits. A user presents one request at a time on a valid/ready handshake. Each request carries a write flag, a word address, write data and a two-bit lane mask. The block then drives the RAM's active-low chip, write and output enables and its two active-low byte enables. It holds the address steady for the whole access and controls a tri-state enable for the shared data bus, which appears here as separate outgoing and incoming halves.

Every timing minimum is a parameter counted in clock cycles: the read access window, the write pulse width and the bus turnaround gap. Reads return the selected lanes with a one-cycle valid strobe, and unselected lanes read as zero. When a write follows a read, the block leaves the bus idle for the turnaround gap before it starts driving, so it never collides with RAM outputs that may still be switching off.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after, ready is 1, chip/write/output/byte enables are all high (inactive), the bus drive enable is 0 and the response strobe is 0.
- R2: A request is taken in a cycle where valid and ready are both 1. From the next cycle ready stays 0 until the access ends, and the RAM address equals the accepted address throughout, whatever the request inputs do meanwhile.
- R3: A read holds chip enable and output enable low, with write enable high, for ACCESS_CYC+1 cycles. The lower byte enable is low exactly when mask bit 0 is 1, and the upper byte enable is low exactly when mask bit 1 is 1.
- R4: Read data is taken from the bus in the last cycle of output enable low. In the next cycle the response strobe is 1 for exactly one cycle, and data bits 7:0 (mask bit 0) and 15:8 (mask bit 1) are zero for unselected lanes.
- R5: A write is one setup cycle (chip enable low, write enable high), then PULSE_CYC cycles of write enable low, then one release cycle with write enable high and chip enable low. Drive is 1 and the outgoing bus equals the accepted write data in all of these cycles.
- R6: A write updates only the bytes selected by the mask (bit 0 for bits 7:0, bit 1 for bits 15:8). The other byte of the word keeps its value.
- R7: If the previously accepted request was a read, a write first spends TURN_CYC cycles with all enables high and drive 0. A write that follows a write, or the first request after reset, has no such gap.
- R8: The bus drive enable is never 1 in a cycle where output enable is low.
- R9: A mask of 00 keeps both byte enables high: the write leaves the word unchanged and the read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | RAM lower byte enable, active low |
| mem_ub_n | output | 1 | RAM upper byte enable, active low |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_in | input | 16 | Data returned from the RAM bus |
| mem_dq_oe | output | 1 | Tri-state drive enable for mem_dq_out |

## Verification
Two things can happen in one cycle: the response strobe of a finished read and the acceptance of the next request, because the response cycle is also an idle cycle with ready high. The bench keeps valid high across back-to-back reads and read-then-write pairs, so the new request is taken exactly in the response cycle. The reference model must then expect the strobe and data of the old read together with the first phase of the new access in the following cycle. That phase is a turnaround gap when the new request is a write. The data check covers both cases: the bench RAM puts junk on disabled lanes, so a response that leaks a lane, or a turnaround that is skipped, shows up as a wrong word or a wrong enable pattern.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    IDLE,
    READ_ACCESS,
    READ_CAPTURE,
    WRITE_SETUP,
    WRITE_PULSE,
    WRITE_RELEASE,
    TURNAROUND
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } strobe_t;

  // Strobe levels that belong to each phase.
  function automatic strobe_t strobes_for(phase_e p);
    strobe_t s;
    s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    case (p)
      READ_ACCESS, READ_CAPTURE: begin
        s.ce_n = 1'b0;
        s.oe_n = 1'b0;
      end
      WRITE_SETUP, WRITE_RELEASE: begin
        s.ce_n  = 1'b0;
        s.drive = 1'b1;
      end
      WRITE_PULSE: begin
        s.ce_n  = 1'b0;
        s.we_n  = 1'b0;
        s.drive = 1'b1;
      end
      default: ;
    endcase
    return s;
  endfunction

  // Phases in which the byte enables follow the mask.
  function automatic logic lanes_active(phase_e p);
    return (p == READ_ACCESS) || (p == READ_CAPTURE) || (p == WRITE_SETUP) ||
           (p == WRITE_PULSE) || (p == WRITE_RELEASE);
  endfunction

  // Zero every byte whose mask bit is clear.
  function automatic logic [DATA_W-1:0] keep_lanes(logic [DATA_W-1:0] d,
                                                   logic [LANES-1:0] m);
    logic [DATA_W-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      r[l*8 +: 8] = m[l] ? d[l*8 +: 8] : 8'h00;
    end
    return r;
  endfunction

  // Cycles spent in a timed phase, minus one (timer reload value).
  function automatic int reload_for(phase_e p, int acc, int pulse, int turn);
    case (p)
      READ_ACCESS: return acc - 1;
      WRITE_PULSE: return pulse - 1;
      TURNAROUND:  return turn - 1;
      default:     return 0;
    endcase
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int ACCESS_CYC = 2,
  parameter int PULSE_CYC  = 2,
  parameter int TURN_CYC   = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output logic   req_ready,
  output logic   accept,
  output logic   capture,
  output phase_e phase_q,
  output phase_e phase_d
);

  localparam int MAX_AP = (ACCESS_CYC > PULSE_CYC) ? ACCESS_CYC : PULSE_CYC;
  localparam int MAX_C  = (MAX_AP > TURN_CYC) ? MAX_AP : TURN_CYC;
  localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  logic             turn_pending_q;
  logic             tmr_load;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_val;

  assign req_ready = (phase_q == IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (phase_q == READ_CAPTURE);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      IDLE: begin
        if (accept) begin
          if (!req_write)         phase_d = READ_ACCESS;
          else if (turn_pending_q) phase_d = TURNAROUND;
          else                    phase_d = WRITE_SETUP;
        end
      end
      READ_ACCESS:   if (tmr_done) phase_d = READ_CAPTURE;
      READ_CAPTURE:  phase_d = IDLE;
      TURNAROUND:    if (tmr_done) phase_d = WRITE_SETUP;
      WRITE_SETUP:   phase_d = WRITE_PULSE;
      WRITE_PULSE:   if (tmr_done) phase_d = WRITE_RELEASE;
      WRITE_RELEASE: phase_d = IDLE;
      default:       phase_d = IDLE;
    endcase
  end

  assign tmr_load = (phase_d != phase_q);
  assign tmr_val  = CNT_W'(reload_for(phase_d, ACCESS_CYC, PULSE_CYC, TURN_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q        <= IDLE;
      turn_pending_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == READ_CAPTURE)    turn_pending_q <= 1'b1;
      else if (phase_q == TURNAROUND) turn_pending_q <= 1'b0;
    end
  end

  sram_lane_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  mask_q,
  output logic [LANES-1:0]  mask_next,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);

  assign mask_next = accept ? req_mask : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= keep_lanes(bus_in, mask_q);
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int ACCESS_CYC = 2,
  parameter int PULSE_CYC  = 2,
  parameter int TURN_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [15:0]       mem_dq_out,
  input  logic [15:0]       mem_dq_in,
  output logic              mem_dq_oe
);

  phase_e           phase_q;
  phase_e           phase_d;
  logic             accept_evt;
  logic             capture_evt;
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] mask_next;
  strobe_t          strobe_d;
  strobe_t          strobe_q;
  logic [LANES-1:0] lane_n_d;
  logic [LANES-1:0] lane_n_q;

  sram_lane_seq #(
    .ACCESS_CYC(ACCESS_CYC),
    .PULSE_CYC (PULSE_CYC),
    .TURN_CYC  (TURN_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept_evt),
    .capture  (capture_evt),
    .phase_q  (phase_q),
    .phase_d  (phase_d)
  );

  sram_lane_dp #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept_evt),
    .capture  (capture_evt),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_mask (req_mask),
    .bus_in   (mem_dq_in),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dq_out),
    .mask_q   (mask_q),
    .mask_next(mask_next),
    .rdata_q  (rsp_rdata),
    .rvalid_q (rsp_valid)
  );

  // Strobes come from flops loaded with the decode of the next phase,
  // so the pins move on the same edge as the phase and never glitch.
  assign strobe_d = strobes_for(phase_d);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_n_d[l] = !(lanes_active(phase_d) && mask_next[l]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
      lane_n_q <= '1;
    end else begin
      strobe_q <= strobe_d;
      lane_n_q <= lane_n_d;
    end
  end

  assign mem_ce_n  = strobe_q.ce_n;
  assign mem_we_n  = strobe_q.we_n;
  assign mem_oe_n  = strobe_q.oe_n;
  assign mem_dq_oe = strobe_q.drive;
  assign mem_lb_n  = lane_n_q[0];
  assign mem_ub_n  = lane_n_q[1];

  logic unused_mask_q;
  assign unused_mask_q = ^mask_q;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [15:0]       mem_dq_out,
  input logic              mem_dq_oe,
  input logic              accept_evt,
  input logic              capture_evt
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready);

  // R3
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  // R4
  rsp_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> rsp_valid);

  // R4
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && !mem_ce_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

  // R7
  drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  // R8
  oe_drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe),
  .accept_evt (accept_evt),
  .capture_evt(capture_evt)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ACC  = 2;
  localparam int PUL  = 2;
  localparam int TRN  = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;
  logic        mem_dq_oe;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit ram_armed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(
    .ADDR_W(16), .ACCESS_CYC(ACC), .PULSE_CYC(PUL), .TURN_CYC(TRN)
  ) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // ---------------- pin-level RAM ----------------
  logic [15:0] ram [int];

  function automatic logic [15:0] ram_rd(int a);
    return ram.exists(a) ? ram[a] : 16'h0000;
  endfunction

  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in = {mem_ub_n ? 8'hA5 : ram_rd(int'(mem_addr))[15:8],
                   mem_lb_n ? 8'h5A : ram_rd(int'(mem_addr))[7:0]};
    else
      mem_dq_in = 16'hC3C3;
  end

  always @(posedge mem_we_n) begin
    if (ram_armed && !mem_ce_n) begin
      logic [15:0] w;
      w = ram_rd(int'(mem_addr));
      if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      ram[int'(mem_addr)] = w;
    end
  end

  // ---------------- reference model ----------------
  typedef struct {
    bit busy; bit ce_n; bit we_n; bit oe_n; bit drv; bit lb_n; bit ub_n; bit cap;
    string tag;
  } ph_t;

  ph_t         q[$];
  ph_t         cur;
  logic [15:0] shadow [int];
  bit          exp_rsp = 0;
  logic [15:0] exp_rdata = '0;
  logic [15:0] pend_rdata = '0;
  logic [15:0] exp_addr = '0;
  logic [15:0] exp_wdata = '0;
  bit          last_rd = 0;
  bit          last_mask0 = 0;
  bit          pend_mask0 = 0;

  function automatic ph_t mk(bit busy, bit ce, bit we, bit oe, bit drv,
                             bit lb, bit ub, bit cap, string tag);
    ph_t p;
    p.busy = busy; p.ce_n = ce; p.we_n = we; p.oe_n = oe; p.drv = drv;
    p.lb_n = lb; p.ub_n = ub; p.cap = cap; p.tag = tag;
    return p;
  endfunction

  function automatic ph_t idle_ph();
    return mk(0, 1, 1, 1, 0, 1, 1, 0, "R1");
  endfunction

  function automatic logic [15:0] sh_rd(int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial cur = idle_ph();

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1 reset state
      chk(req_ready === 1'b1, "R1", "ready in reset", 32'(req_ready), 1);
      chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} === 5'b11111, "R1",
          "enables in reset", 32'({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}), 32'h1f);
      chk(mem_dq_oe === 1'b0 && rsp_valid === 1'b0, "R1", "drive/rsp in reset",
          32'({mem_dq_oe, rsp_valid}), 0);
      cur = idle_ph(); q.delete(); exp_rsp = 0; last_rd = 0;
    end else if (!finished) begin
      bit acc;
      bit [15:0] rd_exp;
      // R2 handshake and held address
      chk(req_ready === !cur.busy, "R2", "ready", 32'(req_ready), 32'(!cur.busy));
      if (cur.busy) chk(mem_addr === exp_addr, "R2", "address held", 32'(mem_addr), 32'(exp_addr));
      chk({mem_ce_n, mem_we_n, mem_oe_n} === {cur.ce_n, cur.we_n, cur.oe_n}, cur.tag,
          "ce/we/oe", 32'({mem_ce_n, mem_we_n, mem_oe_n}), 32'({cur.ce_n, cur.we_n, cur.oe_n}));
      chk({mem_ub_n, mem_lb_n} === {cur.ub_n, cur.lb_n}, (cur.drv ? "R6" : cur.tag),
          "byte enables", 32'({mem_ub_n, mem_lb_n}), 32'({cur.ub_n, cur.lb_n}));
      chk(mem_dq_oe === cur.drv, cur.tag, "drive", 32'(mem_dq_oe), 32'(cur.drv));
      if (cur.drv) chk(mem_dq_out === exp_wdata, "R5", "write data", 32'(mem_dq_out), 32'(exp_wdata));
      // R8
      chk(!(mem_dq_oe && !mem_oe_n), "R8", "drive with oe low", 32'({mem_dq_oe, mem_oe_n}), 32'b01);
      // R4 response strobe and data (R9 for empty mask)
      chk(rsp_valid === exp_rsp, "R4", "rsp_valid", 32'(rsp_valid), 32'(exp_rsp));
      if (exp_rsp)
        chk(rsp_rdata === exp_rdata, (last_mask0 ? "R9" : "R4"), "read data",
            32'(rsp_rdata), 32'(exp_rdata));

      acc = req_valid && !cur.busy;
      if (acc) begin
        exp_addr = req_addr;
        if (req_write) begin
          logic [15:0] w;
          exp_wdata = req_wdata;
          w = sh_rd(int'(req_addr));
          if (req_mask[0]) w[7:0]  = req_wdata[7:0];
          if (req_mask[1]) w[15:8] = req_wdata[15:8];
          shadow[int'(req_addr)] = w;
          if (last_rd)
            for (int i = 0; i < TRN; i++) q.push_back(mk(1, 1, 1, 1, 0, 1, 1, 0, "R7"));
          q.push_back(mk(1, 0, 1, 1, 1, !req_mask[0], !req_mask[1], 0, "R5"));
          for (int i = 0; i < PUL; i++)
            q.push_back(mk(1, 0, 0, 1, 1, !req_mask[0], !req_mask[1], 0, "R5"));
          q.push_back(mk(1, 0, 1, 1, 1, !req_mask[0], !req_mask[1], 0, "R5"));
          last_rd = 0;
        end else begin
          rd_exp = sh_rd(int'(req_addr));
          pend_rdata = {req_mask[1] ? rd_exp[15:8] : 8'h00, req_mask[0] ? rd_exp[7:0] : 8'h00};
          pend_mask0 = (req_mask == 2'b00);
          for (int i = 0; i < ACC; i++)
            q.push_back(mk(1, 0, 1, 0, 0, !req_mask[0], !req_mask[1], 0, "R3"));
          q.push_back(mk(1, 0, 1, 0, 0, !req_mask[0], !req_mask[1], 1, "R3"));
          last_rd = 1;
        end
      end
      exp_rsp = cur.cap;
      if (cur.cap) begin
        exp_rdata = pend_rdata;
        last_mask0 = pend_mask0;
      end
      cur = (q.size() != 0) ? q.pop_front() : idle_ph();
    end
  end

  // ---------------- stimulus ----------------
  task automatic req(bit w, logic [15:0] a, logic [15:0] d, logic [1:0] m);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    // scramble fields while busy: R2 says they are ignored
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_mask = ~m;
  endtask

  task automatic idle(int n);
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    ram_armed = 1;
    // R5/R6 full write, then R3/R4 read, then R7 write after read
    req(1, 16'h0010, 16'h1234, 2'b11);
    req(0, 16'h0010, 16'h0000, 2'b11);
    req(1, 16'h0010, 16'hABCD, 2'b01);   // R6 lower lane only -> 12CD
    req(0, 16'h0010, 16'h0000, 2'b10);   // R4 upper lane -> 1200
    req(0, 16'h0010, 16'h0000, 2'b01);   // R4 lower lane -> 00CD
    idle(3);
    req(1, 16'h0010, 16'h5566, 2'b10);   // R7 after idle gap, R6 -> 55CD
    req(1, 16'h0010, 16'hFFFF, 2'b00);   // R9 write nothing, no turnaround
    req(0, 16'h0010, 16'h0000, 2'b11);   // expect 55CD
    req(0, 16'h0010, 16'h0000, 2'b00);   // R9 read zero
    req(1, 16'hFFFF, 16'hBEEF, 2'b11);   // top address
    req(1, 16'h0000, 16'hCAFE, 2'b11);   // bottom address
    req(0, 16'hFFFF, 16'h0000, 2'b11);
    req(0, 16'h0000, 16'h0000, 2'b11);
    idle(2);
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      req(lfsr[3], {12'h000, lfsr[7:4]}, lfsr[31:16], lfsr[9:8]);
      if (lfsr[12:10] == 3'b000) idle(2);
    end
    idle(12);
    finish_run();
  end

endmodule